// File: doc/BRIEF.md
# Wrap-Around Product Term Sharing Array

This block steers product terms to the macrocells of one logic block. It takes 160 product-term values grouped as 32 clusters of five; cluster c is `pt_in[5c+4:5c]`. For every macrocell it forms the OR of a run of consecutive clusters, chosen per macrocell. The run may pass the top of the array and continue from cluster 0. A macrocell can also skip the sharing network and use only the five terms of its own cluster.

Each macrocell's settings (first cluster, run length, bypass) live in a register bank loaded one entry per cycle through a write port. Each cluster feeds at most one function. When two macrocells claim the same cluster, the one with the lower index gets it and a conflict flag is raised. The sum outputs, the bypass outputs and the conflict flag are registered, so each reflects the inputs and settings one clock edge earlier.

Top module: `ptsa_wrap`

## Requirements
- R1: After reset, entry m holds first cluster m, length 1 and bypass 0. With that setting, `sum_out[m]` equals the OR of cluster m, `byp_out` is 0 and `conflict_out` is 0. All three outputs read 0 while reset is held low.
- R2: On a rising edge with `cfg_we` high, entry `cfg_addr` takes `cfg_start`, `cfg_len` and `cfg_byp`. The outputs reflect the new entry from the following rising edge on. Entries are unchanged when `cfg_we` is low.
- R3: For a macrocell without bypass, the claimed clusters are (start+i) mod 32 for i = 0 .. len-1. `sum_out[m]` is the OR of every term in each claimed cluster that the macrocell owns.
- R4: A run that passes cluster 31 continues at cluster 0, 1 and so on.
- R5: The run length ranges from 1 to 7 clusters, which is up to 35 terms. A length of 0 claims no cluster, so that macrocell's `sum_out` bit is 0.
- R6: A macrocell with bypass set claims only its own cluster. Its `sum_out` bit is 0, and its `byp_out` bit is the OR of its own cluster when it owns that cluster (0 otherwise). `byp_out` bits of macrocells without bypass are 0.
- R7: When more than one macrocell claims a cluster, the lowest-indexed claimant owns it and `conflict_out` is 1. Otherwise `conflict_out` is 0.
- R8: A cluster that no macrocell owns affects no output. When all product terms are 0, every output bit is 0.
- R9: A change on `pt_in` shows on the outputs at the first rising edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pt_in | input | 160 | Product terms, cluster c in bits 5c+4..5c |
| cfg_we | input | 1 | Write strobe for the settings bank |
| cfg_addr | input | 5 | Macrocell entry to write |
| cfg_start | input | 5 | First cluster of the run |
| cfg_len | input | 3 | Run length in clusters, 0 to 7 |
| cfg_byp | input | 1 | Bypass: use only the own cluster |
| sum_out | output | 32 | Registered shared sum per macrocell |
| byp_out | output | 32 | Registered bypass sum per macrocell |
| conflict_out | output | 1 | Registered flag: some cluster has two claimants |

## Verification
The bench goes after a seven-cluster run on macrocell 31 that wraps through clusters 0 to 4. A design that wraps wrongly would drop those clusters or pull in clusters 32 and up, which do not exist. It also sets up overlaps: a shared run that covers a bypassed macrocell's cluster, and a wrapped run that collides with low-indexed macrocells. An inverted priority would hand the contested cluster to the higher index, and a missing flag would leave the conflict silent. Clusters with no owner are lit on their own to catch a design that ORs stray terms into some sum. It also checks length 0 and the one-edge latency from `pt_in`, which catches a design that lets a changed term through before the clock edge or one edge late.

// File: rtl/ptsa_pkg.sv
package ptsa_pkg;
  localparam int MC_N    = 32;
  localparam int TERMS   = 5;
  localparam int RUN_MAX = 7;
  localparam int IDX_W   = $clog2(MC_N);
  localparam int LEN_W   = $clog2(RUN_MAX + 1);
  localparam int PT_W    = MC_N * TERMS;

  typedef struct packed {
    logic             byp;
    logic [LEN_W-1:0] len;
    logic [IDX_W-1:0] start;
  } cfg_t;

  // distance of cluster c after start, taken around the ring of n clusters
  function automatic logic run_covers(int c, int start, int len, int n);
    int d;
    d = (c - start + n) % n;
    return d < len;
  endfunction
endpackage

// File: rtl/ptsa_cfg_bank.sv
module ptsa_cfg_bank
  import ptsa_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 we,
  input  logic [IDX_W-1:0]     addr,
  input  cfg_t                 wdata,
  output cfg_t [MC_N-1:0]      cfg_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int m = 0; m < MC_N; m++) begin
        cfg_o[m].start <= IDX_W'(m);
        cfg_o[m].len   <= LEN_W'(1);
        cfg_o[m].byp   <= 1'b0;
      end
    end else if (we) begin
      cfg_o[addr] <= wdata;
    end
  end

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(cfg_o)) else $error("settings changed without write"); // R2
endmodule

// File: rtl/ptsa_claim.sv
module ptsa_claim
  import ptsa_pkg::*;
(
  input  cfg_t [MC_N-1:0]            cfg_i,
  output logic [MC_N-1:0][MC_N-1:0]  own_o,      // [cluster][macrocell]
  output logic                       conflict_o
);
  logic [MC_N-1:0][MC_N-1:0] claim;
  logic [MC_N-1:0]           multi;

  always_comb begin
    for (int c = 0; c < MC_N; c++) begin
      for (int m = 0; m < MC_N; m++) begin
        if (cfg_i[m].byp) claim[c][m] = (c == m);
        else claim[c][m] = run_covers(c, int'(cfg_i[m].start),
                                      int'(cfg_i[m].len), MC_N);
      end
    end
  end

  // lowest claimant wins: isolate the lowest set bit of each row
  always_comb begin
    for (int c = 0; c < MC_N; c++) begin
      own_o[c] = claim[c] & (~claim[c] + 1'b1);
      multi[c] = |(claim[c] & (claim[c] - 1'b1));
    end
  end

  assign conflict_o = |multi;
endmodule

// File: rtl/ptsa_sum.sv
module ptsa_sum
  import ptsa_pkg::*;
(
  input  logic [PT_W-1:0]            pt_i,
  input  logic [MC_N-1:0][MC_N-1:0]  own_i,
  input  cfg_t [MC_N-1:0]            cfg_i,
  output logic [MC_N-1:0]            sum_o,
  output logic [MC_N-1:0]            byp_o
);
  logic [MC_N-1:0] clor;
  logic [MC_N-1:0] shared;

  genvar g;
  generate
    for (g = 0; g < MC_N; g++) begin : g_clor
      assign clor[g] = |pt_i[g*TERMS +: TERMS];
    end
  endgenerate

  always_comb begin
    shared = '0;
    for (int m = 0; m < MC_N; m++) begin
      for (int c = 0; c < MC_N; c++) begin
        shared[m] = shared[m] | (own_i[c][m] & clor[c]);
      end
    end
  end

  always_comb begin
    for (int m = 0; m < MC_N; m++) begin
      sum_o[m] = cfg_i[m].byp ? 1'b0 : shared[m];
      byp_o[m] = cfg_i[m].byp ? shared[m] : 1'b0;
    end
  end
endmodule

// File: rtl/ptsa_wrap.sv
module ptsa_wrap
  import ptsa_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [PT_W-1:0]    pt_in,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_addr,
  input  logic [IDX_W-1:0]   cfg_start,
  input  logic [LEN_W-1:0]   cfg_len,
  input  logic               cfg_byp,
  output logic [MC_N-1:0]    sum_out,
  output logic [MC_N-1:0]    byp_out,
  output logic               conflict_out
);
  cfg_t                      wdata;
  cfg_t [MC_N-1:0]           cfg;
  logic [MC_N-1:0][MC_N-1:0] own;
  logic                      conflict_c;
  logic [MC_N-1:0]           sum_c, byp_c;
  logic [MC_N-1:0]           byp_vec;     // bypass settings, for checks

  assign wdata.byp   = cfg_byp;
  assign wdata.len   = cfg_len;
  assign wdata.start = cfg_start;

  always_comb
    for (int m = 0; m < MC_N; m++) byp_vec[m] = cfg[m].byp;

  ptsa_cfg_bank u_bank (.clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
                        .wdata(wdata), .cfg_o(cfg));
  ptsa_claim u_claim (.cfg_i(cfg), .own_o(own), .conflict_o(conflict_c));
  ptsa_sum u_sum (.pt_i(pt_in), .own_i(own), .cfg_i(cfg),
                  .sum_o(sum_c), .byp_o(byp_c));

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sum_out      <= '0;
          byp_out      <= '0;
          conflict_out <= 1'b0;
        end else begin
          sum_out      <= sum_c;
          byp_out      <= byp_c;
          conflict_out <= conflict_c;
        end
      end

      AST_ZERO_TERMS: assert property (@(posedge clk) disable iff (!rst_n)
        (pt_in == '0) |=> (sum_out == '0 && byp_out == '0)) else $error("output without terms"); // R8
      AST_SUM_BYP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        ((sum_out & byp_out) == '0)) else $error("macrocell on both paths"); // R6
      AST_BYP_ONLY_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ((byp_out & ~$past(byp_vec)) == '0)) else $error("bypass out without bypass"); // R6
      AST_CONFLICT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_we && !$past(cfg_we)) |=> $stable(conflict_out)) else $error("conflict moved"); // R7
    end else begin : g_comb
      assign sum_out      = sum_c;
      assign byp_out      = byp_c;
      assign conflict_out = conflict_c;
    end
  endgenerate
endmodule

// File: tb/tb_ptsa_wrap.sv
`timescale 1ns/1ps
module tb_ptsa_wrap;
  localparam int N = 32;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [159:0] pt_in = '0;
  logic         cfg_we = 1'b0;
  logic [4:0]   cfg_addr = '0, cfg_start = '0;
  logic [2:0]   cfg_len = '0;
  logic         cfg_byp = 1'b0;
  logic [31:0]  sum_out, byp_out;
  logic         conflict_out;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  int sh_start[N], sh_len[N];
  bit sh_byp[N];
  logic [31:0] e_sum, e_byp;
  logic        e_conf;

  localparam logic [159:0] PAT [6] = '{
    {32{5'b00001}}, {32{5'b10000}}, {160{1'b1}}, 160'h0,
    {16{10'b0000011111}}, {8{20'h0f00f}} };

  ptsa_wrap dut (.clk(clk), .rst_n(rst_n), .pt_in(pt_in), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_start(cfg_start), .cfg_len(cfg_len), .cfg_byp(cfg_byp),
    .sum_out(sum_out), .byp_out(byp_out), .conflict_out(conflict_out));

  always #4 clk = ~clk;

  // model: macrocells take clusters in ascending index order; a cluster already taken is a conflict
  task automatic model(input logic [159:0] pt);
    bit taken[N];
    int cl;
    e_sum = '0; e_byp = '0; e_conf = 1'b0;
    foreach (taken[i]) taken[i] = 0;
    for (int m = 0; m < N; m++) begin
      int cnt = sh_byp[m] ? 1 : sh_len[m];
      for (int i = 0; i < cnt; i++) begin
        cl = sh_byp[m] ? m : (sh_start[m] + i) % N;
        if (taken[cl]) e_conf = 1'b1;
        else begin
          taken[cl] = 1;
          if (pt[cl*5 +: 5] != 5'b0) begin
            if (sh_byp[m]) e_byp[m] = 1'b1; else e_sum[m] = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    model(pt_in);
    chk({req, " sum"}, sum_out, e_sum);
    chk({req, " byp"}, byp_out, e_byp);
    chk({req, " conflict"}, {31'b0, conflict_out}, {31'b0, e_conf});
  endtask

  task automatic wr(input int a, input int s, input int l, input bit b);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 5'(a); cfg_start = 5'(s); cfg_len = 3'(l); cfg_byp = b;
    sh_start[a] = s; sh_len[a] = l; sh_byp[a] = b;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic apply(input logic [159:0] p);
    @(negedge clk); pt_in = p;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic run_table(input string req);
    for (int i = 0; i < 6; i++) begin
      apply(PAT[i]);
      chk_all(req);
    end
  endtask

  function automatic logic [159:0] one_cluster(int c);
    logic [159:0] v = '0;
    v[c*5 + 2] = 1'b1;
    return v;
  endfunction

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    for (int m = 0; m < N; m++) begin sh_start[m] = m; sh_len[m] = 1; sh_byp[m] = 0; end
    pt_in = {160{1'b1}};
    repeat (3) @(negedge clk);
    // R1: outputs 0 while reset held
    chk("R1 reset sum", sum_out, 32'h0);
    chk("R1 reset byp", byp_out, 32'h0);
    chk("R1 reset conflict", {31'b0, conflict_out}, 32'h0);
    rst_n = 1'b1;
    run_table("R1 identity");

    // R9: new terms not visible before the edge, visible after it
    apply(160'h0);
    @(negedge clk); pt_in = one_cluster(7);
    #1 chk("R9 before edge", sum_out, 32'h0);
    @(posedge clk); @(negedge clk);
    chk("R9 after edge", sum_out, 32'h0000_0080);

    // R3 R5: macrocell 4 takes clusters 4..6; 5 and 6 claim nothing
    wr(5, 5, 0, 0); wr(6, 6, 0, 0); wr(4, 4, 3, 0);
    run_table("R3 run");
    apply(one_cluster(6));
    chk("R3 far cluster", sum_out, 32'h0000_0010);

    // R7 R4: macrocell 31 wraps over clusters 30,31,0..4 that lower ones hold
    wr(31, 30, 7, 0);
    apply(one_cluster(2));
    chk("R7 lower wins", sum_out, 32'h0000_0004);
    chk("R7 flag", {31'b0, conflict_out}, 32'h1);
    run_table("R7 overlap");

    // R4 R5: free clusters 0..4 and 30 so the 35-term run is whole
    for (int m = 0; m < 4; m++) wr(m, m, 0, 0);
    wr(4, 4, 0, 0); wr(30, 30, 0, 0);
    apply(one_cluster(3));
    chk("R4 wrap", sum_out, 32'h8000_0000);
    chk("R4 no conflict", {31'b0, conflict_out}, 32'h0);
    apply(one_cluster(30));
    chk("R5 first cluster", sum_out, 32'h8000_0000);
    run_table("R4 wrap");

    // R8: cluster 5 has no owner
    apply(one_cluster(5));
    chk("R8 unowned sum", sum_out, 32'h0);
    chk("R8 unowned byp", byp_out, 32'h0);

    // R6: bypass on 10, then macrocell 9 run over cluster 10 takes it
    wr(10, 0, 5, 1);
    apply(one_cluster(10));
    chk("R6 bypass byp", byp_out, 32'h0000_0400);
    chk("R6 bypass sum", sum_out, 32'h0);
    wr(9, 9, 2, 0);
    apply(one_cluster(10));
    chk("R6 bypass lost byp", byp_out, 32'h0);
    chk("R6 bypass lost sum", sum_out, 32'h0000_0200);
    run_table("R6 bypass");

    // R2: write to entry 9 changes only entry 9
    wr(9, 20, 1, 0);
    apply(one_cluster(20));
    chk("R2 rewrite", sum_out, 32'h0000_0200);
    run_table("R2 rewrite");

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule